// File: doc/BRIEF.md
# BCD Calendar Clock with Hundredths

This block keeps a running calendar in packed BCD fields: hundredths of a second, seconds, minutes, hours, day of week, date, month and a two-digit year. It moves forward by one hundredth on each cycle in which the 100 Hz `tick` strobe is high. A carry passes from each field to the next, so one tick can change every field at once. Month lengths and leap years are handled without help from the host. The hours field counts in either 24-hour form or 12-hour form, and 12-hour form carries an AM/PM flag.

A host sets the clock through a parallel load port. When `load` is high, every field takes the value on the `ld_*` inputs, and in that cycle the tick is ignored. The current value of every field is always present on the `q_*` outputs. Each output comes straight from a register and changes one clock after the edge at which `tick` or `load` was sampled.

Only one step of the hours counter has more than one outcome, so that step is written as a small decision with four named kinds:
- **HS_COUNT**: ordinary BCD increment.
- **HS_NOON_FLIP**: 11 goes to 12 and AM/PM toggles.
- **HS_TWELVE_WRAP**: 12 goes to 01 in 12-hour form.
- **HS_DAY_WRAP**: 23 goes to 00 in 24-hour form.

The day carries into the date on HS_DAY_WRAP. It also carries on HS_NOON_FLIP when the flag goes from PM to AM.

Top module: `bcd_calendar_clock`

## Requirements
- R1: With `load` low, each clock cycle with `tick` high advances hundredths by one in BCD, counting 00 to 99 and then wrapping to 00.
- R2: The wrap of hundredths advances seconds. The wrap of seconds (59 to 00) advances minutes. The wrap of minutes (59 to 00) advances hours. All of these changes happen in the same cycle.
- R3: With `q_mode12` = 0, hours count 00 to 23. The step from 23 to 00 advances the date and the day of week.
- R4: With `q_mode12` = 1, hours run 12, 01, 02, ... 11. `q_pm` toggles on the step from 11 to 12, where 1 means PM. The step from 12 goes to 01 and leaves `q_pm` unchanged. In 24-hour form `q_pm` holds its value.
- R5: In 12-hour form, the date advances only on the step from 11 PM to 12 AM. The step from 11 AM to 12 PM leaves the date unchanged.
- R6: After the last day of its month, the date wraps to 01 and the month advances. The last day is 30 for months 04, 06, 09 and 11, and 31 for months 01, 03, 05, 07, 08, 10 and 12.
- R7: February ends on day 29 when the year value is divisible by 4, with year 00 counted as leap. In every other year it ends on day 28.
- R8: Day of week counts 1 to 7 in 3-bit binary and advances with every date step. It wraps from 7 to 1.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R10: When `load` is high, every field takes its `ld_*` value on the next edge. Load wins over a `tick` in the same cycle, and that tick has no effect.
- R11: Reset (`rst_n` low) sets the clock to 00:00:00.00 in 24-hour form with `q_pm` = 0, day of week 1, date 01, month 01 and year 00.
- R12: In a cycle with both `tick` and `load` low, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 100 Hz advance strobe, one cycle wide |
| load | input | 1 | Overwrite all fields from the ld_* inputs |
| ld_hund | input | 8 | Hundredths to load, BCD |
| ld_sec | input | 7 | Seconds to load, BCD |
| ld_min | input | 7 | Minutes to load, BCD |
| ld_hour | input | 6 | Hours to load, BCD |
| ld_pm | input | 1 | AM/PM flag to load, 1 = PM |
| ld_mode12 | input | 1 | Hour form to load, 1 = 12-hour |
| ld_dow | input | 3 | Day of week to load, 1..7 |
| ld_date | input | 6 | Date to load, BCD |
| ld_month | input | 5 | Month to load, BCD |
| ld_year | input | 8 | Year to load, BCD |
| q_hund | output | 8 | Hundredths, BCD |
| q_sec | output | 7 | Seconds, BCD |
| q_min | output | 7 | Minutes, BCD |
| q_hour | output | 6 | Hours, BCD |
| q_pm | output | 1 | AM/PM flag, 1 = PM |
| q_mode12 | output | 1 | Hour form, 1 = 12-hour |
| q_dow | output | 3 | Day of week, 1..7 |
| q_date | output | 6 | Date, BCD |
| q_month | output | 5 | Month, BCD |
| q_year | output | 8 | Year, BCD |

## Verification
Every field is one register deep, so the result of a tick or a load is due exactly one clock after the rising edge that samples it. This holds for a full carry from hundredths up to the year as well. The bench drives `tick`, `load` and the `ld_*` inputs on the falling edge and updates its own calendar model at the same time. It then compares all ten outputs on the next falling edge, so each comparison sees the state after exactly one rising edge. Idle cycles are checked in the same way, against a model that does not change.

// File: rtl/cal_pkg.sv
package cal_pkg;

    // Kind of step the hours counter takes on a carry from minutes.
    typedef enum logic [1:0] {
        HS_COUNT       = 2'd0,
        HS_NOON_FLIP   = 2'd1,
        HS_TWELVE_WRAP = 2'd2,
        HS_DAY_WRAP    = 2'd3
    } hour_step_e;

    localparam int HUND_W  = 8;
    localparam int SEC_W   = 7;
    localparam int MIN_W   = 7;
    localparam int HOUR_W  = 6;
    localparam int DOW_W   = 3;
    localparam int DATE_W  = 6;
    localparam int MONTH_W = 5;
    localparam int YEAR_W  = 8;

    // Leap test on a BCD year: 10*t + o is divisible by 4 exactly when 2*t + o is.
    function automatic logic is_leap(input logic [YEAR_W-1:0] yr);
        logic [4:0] s;
        s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    // Last date of a month, in BCD.
    function automatic logic [DATE_W-1:0] last_date(input logic [MONTH_W-1:0] mon,
                                                    input logic [YEAR_W-1:0]  yr);
        logic [DATE_W-1:0] r;
        case (mon)
            5'h02:                      r = is_leap(yr) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcd_roll_counter.sv
module bcd_roll_counter #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   FLOOR   = '0,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] val,
    output logic         wrap
);

    logic [W-1:0] cur;
    logic [W-1:0] nxt_inc;

    generate
        if (W <= 4) begin : g_bin
            assign nxt_inc = cur + W'(1);
        end else begin : g_bcd
            localparam int TW = W - 4;
            assign nxt_inc = (cur[3:0] == 4'd9) ? {cur[W-1:4] + TW'(1), 4'd0}
                                                : {cur[W-1:4], cur[3:0] + 4'd1};
        end
    endgenerate

    assign wrap = step && (cur == top_val);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= RST_VAL;
        else if (load)
            cur <= load_val;
        else if (step)
            cur <= (cur == top_val) ? FLOOR : nxt_inc;
    end

    assign val = cur;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (val == $past(load_val)));                           // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(val));                           // R12
    AST_WRAP_TO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && wrap) |=> (val == FLOOR));                          // R2

endmodule

// File: rtl/hour_keeper.sv
module hour_keeper
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [HOUR_W-1:0] ld_hour,
    input  logic              ld_pm,
    input  logic              ld_mode12,
    output logic [HOUR_W-1:0] hour,
    output logic              pm,
    output logic              mode12,
    output logic              day_carry
);

    hour_step_e        kind;
    logic [HOUR_W-1:0] hr_q, hr_inc, hr_nxt;
    logic              pm_q, pm_nxt, m12_q;

    assign hr_inc = (hr_q[3:0] == 4'd9) ? {hr_q[5:4] + 2'd1, 4'd0}
                                        : {hr_q[5:4], hr_q[3:0] + 4'd1};

    always_comb begin
        if (m12_q) begin
            if (hr_q == 6'h11)      kind = HS_NOON_FLIP;
            else if (hr_q == 6'h12) kind = HS_TWELVE_WRAP;
            else                    kind = HS_COUNT;
        end else begin
            if (hr_q == 6'h23)      kind = HS_DAY_WRAP;
            else                    kind = HS_COUNT;
        end
    end

    always_comb begin
        hr_nxt    = hr_inc;
        pm_nxt    = pm_q;
        day_carry = 1'b0;
        unique case (kind)
            HS_COUNT: begin
                hr_nxt = hr_inc;
            end
            HS_NOON_FLIP: begin
                hr_nxt    = 6'h12;
                pm_nxt    = ~pm_q;
                day_carry = step && pm_q;
            end
            HS_TWELVE_WRAP: begin
                hr_nxt = 6'h01;
            end
            HS_DAY_WRAP: begin
                hr_nxt    = 6'h00;
                day_carry = step;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hr_q  <= 6'h00;
            pm_q  <= 1'b0;
            m12_q <= 1'b0;
        end else if (load) begin
            hr_q  <= ld_hour;
            pm_q  <= ld_pm;
            m12_q <= ld_mode12;
        end else if (step) begin
            hr_q  <= hr_nxt;
            pm_q  <= pm_nxt;
        end
    end

    assign hour   = hr_q;
    assign pm     = pm_q;
    assign mode12 = m12_q;

    AST_HOUR_24_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && !m12_q && hr_q == 6'h23) |=> (hour == 6'h00));   // R3
    AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && m12_q && hr_q == 6'h11) |=> (pm != $past(pm)));  // R4
    AST_TWELVE_KEEPS_PM: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && m12_q && hr_q == 6'h12) |=> (hour == 6'h01 && $stable(pm))); // R4
    AST_NO_NOON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && m12_q && hr_q == 6'h11 && !pm_q) |-> !day_carry);         // R5

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import cal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               load,
    input  logic [HUND_W-1:0]  ld_hund,
    input  logic [SEC_W-1:0]   ld_sec,
    input  logic [MIN_W-1:0]   ld_min,
    input  logic [HOUR_W-1:0]  ld_hour,
    input  logic               ld_pm,
    input  logic               ld_mode12,
    input  logic [DOW_W-1:0]   ld_dow,
    input  logic [DATE_W-1:0]  ld_date,
    input  logic [MONTH_W-1:0] ld_month,
    input  logic [YEAR_W-1:0]  ld_year,
    output logic [HUND_W-1:0]  q_hund,
    output logic [SEC_W-1:0]   q_sec,
    output logic [MIN_W-1:0]   q_min,
    output logic [HOUR_W-1:0]  q_hour,
    output logic               q_pm,
    output logic               q_mode12,
    output logic [DOW_W-1:0]   q_dow,
    output logic [DATE_W-1:0]  q_date,
    output logic [MONTH_W-1:0] q_month,
    output logic [YEAR_W-1:0]  q_year
);

    logic adv;
    logic w_hund, w_sec, w_min, w_date, w_month;
    logic w_dow_unused, w_year_unused;
    logic day_step;
    logic [DATE_W-1:0] month_end;

    assign adv       = tick && !load;
    assign month_end = last_date(q_month, q_year);

    bcd_roll_counter #(.W(HUND_W), .FLOOR(8'h00), .RST_VAL(8'h00)) u_hund (
        .clk(clk), .rst_n(rst_n), .load(load), .step(adv),
        .load_val(ld_hund), .top_val(8'h99), .val(q_hund), .wrap(w_hund));

    bcd_roll_counter #(.W(SEC_W), .FLOOR(7'h00), .RST_VAL(7'h00)) u_sec (
        .clk(clk), .rst_n(rst_n), .load(load), .step(w_hund),
        .load_val(ld_sec), .top_val(7'h59), .val(q_sec), .wrap(w_sec));

    bcd_roll_counter #(.W(MIN_W), .FLOOR(7'h00), .RST_VAL(7'h00)) u_min (
        .clk(clk), .rst_n(rst_n), .load(load), .step(w_sec),
        .load_val(ld_min), .top_val(7'h59), .val(q_min), .wrap(w_min));

    hour_keeper u_hour (
        .clk(clk), .rst_n(rst_n), .load(load), .step(w_min),
        .ld_hour(ld_hour), .ld_pm(ld_pm), .ld_mode12(ld_mode12),
        .hour(q_hour), .pm(q_pm), .mode12(q_mode12), .day_carry(day_step));

    bcd_roll_counter #(.W(DOW_W), .FLOOR(3'd1), .RST_VAL(3'd1)) u_dow (
        .clk(clk), .rst_n(rst_n), .load(load), .step(day_step),
        .load_val(ld_dow), .top_val(3'd7), .val(q_dow), .wrap(w_dow_unused));

    bcd_roll_counter #(.W(DATE_W), .FLOOR(6'h01), .RST_VAL(6'h01)) u_date (
        .clk(clk), .rst_n(rst_n), .load(load), .step(day_step),
        .load_val(ld_date), .top_val(month_end), .val(q_date), .wrap(w_date));

    bcd_roll_counter #(.W(MONTH_W), .FLOOR(5'h01), .RST_VAL(5'h01)) u_month (
        .clk(clk), .rst_n(rst_n), .load(load), .step(w_date),
        .load_val(ld_month), .top_val(5'h12), .val(q_month), .wrap(w_month));

    bcd_roll_counter #(.W(YEAR_W), .FLOOR(8'h00), .RST_VAL(8'h00)) u_year (
        .clk(clk), .rst_n(rst_n), .load(load), .step(w_month),
        .load_val(ld_year), .top_val(8'h99), .val(q_year), .wrap(w_year_unused));

    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && q_hund != 8'h99) |=> (q_hund != $past(q_hund)));             // R1
    AST_LOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && load) |=> (q_hund == $past(ld_hund) && q_sec == $past(ld_sec))); // R10
    AST_LEAP_FEB: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && day_step && q_month == 5'h02 && q_date == 6'h28 && !is_leap(q_year))
        |=> (q_month == 5'h03 && q_date == 6'h01));                          // R7
    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && day_step && q_dow == 3'd7) |=> (q_dow == 3'd1));           // R8
    AST_YEAR_FOLLOWS_MONTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && w_month) |=> (q_month == 5'h01));                          // R9

endmodule

// File: tb/tb_bcd_calendar_clock.sv
module tb_bcd_calendar_clock;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int h; int s; int m; int hr; int pm; int m12;
        int dow; int d; int mo; int y;
    } tm_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic load = 1'b0;
    logic [7:0] ld_hund = '0;
    logic [6:0] ld_sec = '0;
    logic [6:0] ld_min = '0;
    logic [5:0] ld_hour = '0;
    logic       ld_pm = 1'b0;
    logic       ld_mode12 = 1'b0;
    logic [2:0] ld_dow = 3'd1;
    logic [5:0] ld_date = 6'h01;
    logic [4:0] ld_month = 5'h01;
    logic [7:0] ld_year = '0;
    logic [7:0] q_hund;
    logic [6:0] q_sec;
    logic [6:0] q_min;
    logic [5:0] q_hour;
    logic       q_pm;
    logic       q_mode12;
    logic [2:0] q_dow;
    logic [5:0] q_date;
    logic [4:0] q_month;
    logic [7:0] q_year;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    tm_t exp_t;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_calendar_clock dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .ld_hund(ld_hund), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_pm(ld_pm), .ld_mode12(ld_mode12), .ld_dow(ld_dow), .ld_date(ld_date),
        .ld_month(ld_month), .ld_year(ld_year),
        .q_hund(q_hund), .q_sec(q_sec), .q_min(q_min), .q_hour(q_hour),
        .q_pm(q_pm), .q_mode12(q_mode12), .q_dow(q_dow), .q_date(q_date),
        .q_month(q_month), .q_year(q_year));

    function automatic int from_bcd(input int v);
        return ((v >> 4) * 10) + (v & 15);
    endfunction

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int days_of(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic tm_t advance(input tm_t t);
        tm_t n = t;
        bit nd = 0;
        n.h++;
        if (n.h == 100) begin
            n.h = 0; n.s++;
            if (n.s == 60) begin
                n.s = 0; n.m++;
                if (n.m == 60) begin
                    n.m = 0;
                    if (n.m12 != 0) begin
                        if (n.hr == 11) begin
                            n.hr = 12; n.pm = 1 - n.pm;
                            if (n.pm == 0) nd = 1;
                        end else if (n.hr == 12) n.hr = 1;
                        else n.hr++;
                    end else begin
                        n.hr++;
                        if (n.hr == 24) begin n.hr = 0; nd = 1; end
                    end
                end
            end
        end
        if (nd) begin
            n.dow = (n.dow == 7) ? 1 : n.dow + 1;
            n.d++;
            if (n.d > days_of(n.mo, n.y)) begin
                n.d = 1; n.mo++;
                if (n.mo == 13) begin n.mo = 1; n.y = (n.y + 1) % 100; end
            end
        end
        return n;
    endfunction

    function automatic tm_t mk(input int hr, input int m, input int s, input int h,
                               input int pm, input int m12, input int dow,
                               input int d, input int mo, input int y);
        tm_t t;
        t.h = h; t.s = s; t.m = m; t.hr = hr; t.pm = pm; t.m12 = m12;
        t.dow = dow; t.d = d; t.mo = mo; t.y = y;
        return t;
    endfunction

    task automatic cmp(input string tag, input string fld, input int act, input int ex);
        checks++;
        if (act != ex) begin
            failures++;
            $display("FAIL %s field=%s actual=%0d expected=%0d", tag, fld, act, ex);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "hund",  from_bcd(int'(q_hund)),  exp_t.h);
        cmp(tag, "sec",   from_bcd(int'(q_sec)),   exp_t.s);
        cmp(tag, "min",   from_bcd(int'(q_min)),   exp_t.m);
        cmp(tag, "hour",  from_bcd(int'(q_hour)),  exp_t.hr);
        cmp(tag, "pm",    int'(q_pm),              exp_t.pm);
        cmp(tag, "mode12",int'(q_mode12),          exp_t.m12);
        cmp(tag, "dow",   int'(q_dow),             exp_t.dow);
        cmp(tag, "date",  from_bcd(int'(q_date)),  exp_t.d);
        cmp(tag, "month", from_bcd(int'(q_month)), exp_t.mo);
        cmp(tag, "year",  from_bcd(int'(q_year)),  exp_t.y);
    endtask

    // Called at a falling edge; drives one cycle, checks at the next falling edge.
    task automatic cycle(input bit t, input bit l, input tm_t v, input string tag);
        tick = t; load = l;
        ld_hund = 8'(to_bcd(v.h)); ld_sec = 7'(to_bcd(v.s)); ld_min = 7'(to_bcd(v.m));
        ld_hour = 6'(to_bcd(v.hr)); ld_pm = v.pm[0]; ld_mode12 = v.m12[0];
        ld_dow = 3'(v.dow); ld_date = 6'(to_bcd(v.d)); ld_month = 5'(to_bcd(v.mo));
        ld_year = 8'(to_bcd(v.y));
        if (l) exp_t = v;
        else if (t) exp_t = advance(exp_t);
        @(negedge clk);
        tick = 1'b0; load = 1'b0;
        check_all(tag);
    endtask

    task automatic set_and_tick(input tm_t v, input string tag);
        cycle(0, 1, v, tag);
        cycle(1, 0, v, tag);
    endtask

    function automatic tm_t rand_time();
        tm_t t;
        t.m12 = int'($urandom_range(0, 1));
        t.pm  = int'($urandom_range(0, 1));
        t.hr  = (t.m12 != 0) ? int'($urandom_range(1, 12)) : int'($urandom_range(0, 23));
        t.mo  = int'($urandom_range(1, 12));
        t.y   = int'($urandom_range(0, 99));
        t.d   = int'($urandom_range(1, days_of(t.mo, t.y)));
        t.dow = int'($urandom_range(1, 7));
        t.h   = int'($urandom_range(0, 99));
        t.s   = ($urandom_range(0, 1) != 0) ? 59 : int'($urandom_range(0, 59));
        t.m   = ($urandom_range(0, 1) != 0) ? 59 : int'($urandom_range(0, 59));
        if ($urandom_range(0, 1) != 0) t.d = days_of(t.mo, t.y);
        return t;
    endfunction

    initial begin
        tm_t z;
        z = mk(0, 0, 0, 0, 0, 0, 1, 1, 1, 0);
        void'($urandom(32'd1357));
        exp_t = z;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R11 reset state");

        for (int i = 0; i < 3; i++) cycle(0, 0, z, "R12 idle hold");
        for (int i = 0; i < 120; i++) cycle(1, 0, z, "R1 R2 hundredths count");

        // Load beats tick in the same cycle.
        cycle(1, 1, mk(7, 30, 15, 42, 1, 1, 3, 9, 6, 21), "R10 load over tick");
        for (int i = 0; i < 3; i++) cycle(0, 0, z, "R12 idle after load");

        set_and_tick(mk(23, 59, 59, 99, 0, 0, 7, 31, 12, 99), "R9 R8 R3 year rollover");
        set_and_tick(mk(23, 59, 59, 99, 0, 0, 2, 28, 2, 4),  "R7 leap feb 28 y04");
        set_and_tick(mk(23, 59, 59, 99, 0, 0, 2, 29, 2, 4),  "R7 leap feb 29 y04");
        set_and_tick(mk(23, 59, 59, 99, 0, 0, 2, 28, 2, 1),  "R7 plain feb y01");
        set_and_tick(mk(23, 59, 59, 99, 0, 0, 2, 28, 2, 0),  "R7 leap feb y00");
        set_and_tick(mk(23, 59, 59, 99, 0, 0, 5, 30, 4, 10), "R6 april end");
        set_and_tick(mk(23, 59, 59, 99, 0, 0, 5, 30, 1, 10), "R6 january 30");
        set_and_tick(mk(11, 59, 59, 99, 0, 1, 4, 31, 1, 10), "R4 R5 noon flip");
        set_and_tick(mk(11, 59, 59, 99, 1, 1, 4, 31, 1, 10), "R4 R5 midnight flip");
        set_and_tick(mk(12, 59, 59, 99, 1, 1, 4, 15, 3, 10), "R4 twelve to one");
        set_and_tick(mk(9, 59, 59, 99, 1, 0, 4, 15, 3, 10),  "R3 R4 pm held 24h");

        for (int r = 0; r < 60; r++) begin
            cycle(0, 1, rand_time(), "R10 random load");
            for (int k = 0; k < 250; k++)
                cycle(($urandom_range(0, 3) != 0), 0, z, "R1 R2 R3 R4 R6 R8 random run");
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule